// File: doc/BRIEF.md
# Converter Bus Front End with Control Byte and Split Result Read

This block is the digital side of a 10-bit, eight-input successive-approximation converter that shares one 8-bit bus with a host. The bus is three-state. The host writes a control byte with a write strobe while chip select is low. The block decodes that byte into these settings:

- power mode
- clock source for the conversion
- acquisition style
- single-ended or pseudo-differential input
- unipolar or bipolar coding
- input channel

The block then runs a conversion and pulls an active-low done flag low when it finishes. The host reads the result as two bytes and picks which byte with a high-byte-select input.

A counter stands in for the conversion core. At the end of the count the block captures the 10-bit value on `sample_i`. The host can pace the conversion in two ways:

- **External clock mode:** the conversion advances on rising edges of `ext_clk_i`, counted only while chip select is low.
- **Internal clock mode:** the conversion advances on every cycle of `clk_i`, so it takes a fixed time.

All strobes are sampled synchronously to `clk_i`, and the edge where a strobe is first seen low is the event. The bus is modelled as a data input, a data output and an output enable.

Top module: `adc_bus_ctrl`

## Requirements
- R1: On the first clock edge where `cs_ni` and `wr_ni` are both low, the byte on `bus_i` is captured. Its bits are decoded as follows: bits 7:6 to `pd_mode_o`, bit 5 to `acq_ext_o`, bit 4 to `single_ended_o`, bit 3 to `unipolar_o`, and bits 2:0 to `chan_o`.
- R2: A captured byte with bit 7 set selects the clock source from bit 6, where 1 means external and 0 means internal. `clk_ext_o` shows the source in use.
- R3: A captured byte with bit 7 clear is a power-down request. It leaves `clk_ext_o` unchanged, starts no conversion and cancels any conversion in progress.
- R4: After reset, `clk_ext_o` is 1, `int_no` is 1 and `bus_oe_o` is 0.
- R5: While `cs_ni` is high, the following hold: write strobes change no decoded field, `bus_oe_o` stays 0, and edges on `ext_clk_i` do not advance a conversion.
- R6: `bus_oe_o` is 1 exactly while `cs_ni` and `rd_ni` are both low. With `hben_i`=0, `bus_o` carries result bits 7:0.
- R7: With `hben_i`=1, `bus_o[1:0]` carries result bits 9:8. `bus_o[7:2]` is all zeros when `unipolar_o`=1 and all copies of result bit 9 when `unipolar_o`=0.
- R8: In internal clock mode, a start byte (bit 7 set, bit 5 clear) makes `int_no` go low exactly ACQ_TICKS+INT_CONV_CYCLES clock edges after the capture edge. From that moment the result holds the value of `sample_i`.
- R9: In external clock mode, `int_no` goes low on the ACQ_TICKS+EXT_CONV_TICKS-th counted rising edge of `ext_clk_i` after the capture.
- R10: Once low, `int_no` returns high on the edge after a read strobe (`cs_ni` and `rd_ni` low) or after a captured write.
- R11: A start byte captured during acquisition or conversion cancels the run in progress and restarts the timing of R8/R9 from the new capture.
- R12: A byte with bit 5 set holds the block in acquisition with no time limit. The next start byte with bit 5 clear begins conversion at once, so in internal mode `int_no` falls INT_CONV_CYCLES edges after that capture.
- R13: If a captured write falls on the same edge as the completion of a conversion, the write wins: `int_no` stays high and the stored result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| hben_i | input | 1 | Selects the upper result byte on a read |
| ext_clk_i | input | 1 | External conversion clock |
| bus_i | input | 8 | Bus value seen by the block (control byte) |
| sample_i | input | RES_W | Value the conversion stub delivers |
| bus_o | output | 8 | Bus value driven on a read |
| bus_oe_o | output | 1 | Bus drive enable; 0 means high impedance |
| int_no | output | 1 | Conversion done flag, active low |
| clk_ext_o | output | 1 | 1 when the external clock is the active source |
| pd_mode_o | output | 2 | Power-mode field of the last captured byte |
| acq_ext_o | output | 1 | Acquisition-style field |
| single_ended_o | output | 1 | Input-configuration field |
| unipolar_o | output | 1 | Coding field; 1 means unipolar |
| chan_o | output | 3 | Channel address field |

## Verification
The sharpest collision is a control-byte write landing on the very edge where a conversion finishes. The bench arranges this by counting edges from one internal-mode start and placing a second write on exactly the completion edge, after changing `sample_i`. It then checks two things: the done flag stays high, and a low-byte read still returns the older value. A second pairing is a write arriving mid-conversion; it must restart the full timing from the new capture rather than finish the old run.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ACQ,
    SEQ_HOLD,
    SEQ_CONV
  } seq_state_e;

  // bit order is the host-visible byte layout
  typedef struct packed {
    logic [1:0] pd;
    logic       acq_ext;
    logic       single_ended;
    logic       unipolar;
    logic [2:0] chan;
  } ctrl_byte_t;
endpackage

// File: rtl/adc_strobe_det.sv
module adc_strobe_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic wr_ni,
  input  logic rd_ni,
  input  logic ext_clk_i,
  output logic wr_evt_o,
  output logic rd_evt_o,
  output logic ext_tick_o
);
  logic wr_act, rd_act;
  logic wr_act_q, rd_act_q, ext_q;

  assign wr_act = !cs_ni && !wr_ni;
  assign rd_act = !cs_ni && !rd_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      ext_q    <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      ext_q    <= ext_clk_i;
    end
  end

  assign wr_evt_o   = wr_act && !wr_act_q;
  assign rd_evt_o   = rd_act && !rd_act_q;
  // external clock is gated off while deselected
  assign ext_tick_o = !cs_ni && ext_clk_i && !ext_q;
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_bus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_evt_i,
  input  logic [BUS_W-1:0] bus_i,
  output ctrl_byte_t       ctrl_o,
  output logic             clk_ext_o
);
  ctrl_byte_t byte_in;
  assign byte_in = ctrl_byte_t'(bus_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      clk_ext_o <= 1'b1;
    end else if (wr_evt_i) begin
      ctrl_o <= byte_in;
      // power-down requests keep the clock source
      if (byte_in.pd[1]) clk_ext_o <= byte_in.pd[0];
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_bus_pkg::*;
#(
  parameter int RES_W           = 10,
  parameter int ACQ_TICKS       = 6,
  parameter int EXT_CONV_TICKS  = 10,
  parameter int INT_CONV_CYCLES = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_evt_i,
  input  logic             wr_run_i,
  input  logic             wr_acq_ext_i,
  input  logic             rd_evt_i,
  input  logic             ext_tick_i,
  input  logic             clk_ext_i,
  input  logic [RES_W-1:0] sample_i,
  output logic [RES_W-1:0] result_o,
  output logic             int_no,
  output logic             busy_o
);
  localparam int MAX_A = (ACQ_TICKS > EXT_CONV_TICKS) ? ACQ_TICKS : EXT_CONV_TICKS;
  localparam int MAX_T = (MAX_A > INT_CONV_CYCLES) ? MAX_A : INT_CONV_CYCLES;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_TICKS - 1);
  localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(EXT_CONV_TICKS - 1);
  localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INT_CONV_CYCLES - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic [CNT_W-1:0] conv_last;

  assign tick      = clk_ext_i ? ext_tick_i : 1'b1;
  assign conv_last = clk_ext_i ? EXT_LAST : INT_LAST;
  assign busy_o    = (state_q == SEQ_CONV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      result_o <= '0;
      int_no   <= 1'b1;
    end else if (wr_evt_i) begin
      // a write always wins over completion and restarts timing
      int_no <= 1'b1;
      cnt_q  <= '0;
      if (!wr_run_i)                 state_q <= SEQ_IDLE;
      else if (wr_acq_ext_i)         state_q <= SEQ_HOLD;
      else if (state_q == SEQ_HOLD)  state_q <= SEQ_CONV;
      else                           state_q <= SEQ_ACQ;
    end else begin
      if (rd_evt_i) int_no <= 1'b1;
      unique case (state_q)
        SEQ_ACQ: begin
          if (tick) begin
            if (cnt_q == ACQ_LAST) begin
              state_q <= SEQ_CONV;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        SEQ_CONV: begin
          if (tick) begin
            if (cnt_q == conv_last) begin
              state_q  <= SEQ_IDLE;
              cnt_q    <= '0;
              result_o <= sample_i;
              int_no   <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
  import adc_bus_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             hben_i,
  input  logic             unipolar_i,
  input  logic [RES_W-1:0] result_i,
  output logic [BUS_W-1:0] bus_o,
  output logic             bus_oe_o
);
  localparam int HI_W = RES_W - BUS_W;

  logic fill;
  assign fill     = unipolar_i ? 1'b0 : result_i[RES_W-1];
  assign bus_oe_o = !cs_ni && !rd_ni;

  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    if (i < HI_W) begin : g_hi
      assign bus_o[i] = hben_i ? result_i[BUS_W+i] : result_i[i];
    end else begin : g_fill
      assign bus_o[i] = hben_i ? fill : result_i[i];
    end
  end
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int RES_W           = 10,
  parameter int ACQ_TICKS       = 6,
  parameter int EXT_CONV_TICKS  = 10,
  parameter int INT_CONV_CYCLES = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             wr_ni,
  input  logic             rd_ni,
  input  logic             hben_i,
  input  logic             ext_clk_i,
  input  logic [7:0]       bus_i,
  input  logic [RES_W-1:0] sample_i,
  output logic [7:0]       bus_o,
  output logic             bus_oe_o,
  output logic             int_no,
  output logic             clk_ext_o,
  output logic [1:0]       pd_mode_o,
  output logic             acq_ext_o,
  output logic             single_ended_o,
  output logic             unipolar_o,
  output logic [2:0]       chan_o
);
  logic             wr_evt, rd_evt, ext_tick;
  logic             conv_busy;
  logic [RES_W-1:0] result;
  ctrl_byte_t       ctrl;
  ctrl_byte_t       bus_byte;

  assign bus_byte = ctrl_byte_t'(bus_i);

  adc_strobe_det u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .wr_ni      (wr_ni),
    .rd_ni      (rd_ni),
    .ext_clk_i  (ext_clk_i),
    .wr_evt_o   (wr_evt),
    .rd_evt_o   (rd_evt),
    .ext_tick_o (ext_tick)
  );

  adc_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_evt_i  (wr_evt),
    .bus_i     (bus_i),
    .ctrl_o    (ctrl),
    .clk_ext_o (clk_ext_o)
  );

  adc_conv_seq #(
    .RES_W           (RES_W),
    .ACQ_TICKS       (ACQ_TICKS),
    .EXT_CONV_TICKS  (EXT_CONV_TICKS),
    .INT_CONV_CYCLES (INT_CONV_CYCLES)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_evt_i     (wr_evt),
    .wr_run_i     (bus_byte.pd[1]),
    .wr_acq_ext_i (bus_byte.acq_ext),
    .rd_evt_i     (rd_evt),
    .ext_tick_i   (ext_tick),
    .clk_ext_i    (clk_ext_o),
    .sample_i     (sample_i),
    .result_o     (result),
    .int_no       (int_no),
    .busy_o       (conv_busy)
  );

  adc_read_mux #(.RES_W(RES_W)) u_mux (
    .cs_ni      (cs_ni),
    .rd_ni      (rd_ni),
    .hben_i     (hben_i),
    .unipolar_i (ctrl.unipolar),
    .result_i   (result),
    .bus_o      (bus_o),
    .bus_oe_o   (bus_oe_o)
  );

  assign pd_mode_o      = ctrl.pd;
  assign acq_ext_o      = ctrl.acq_ext;
  assign single_ended_o = ctrl.single_ended;
  assign unipolar_o     = ctrl.unipolar;
  assign chan_o         = ctrl.chan;
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       hben_i,
  input logic       wr_run_i,
  input logic       wr_evt_i,
  input logic       busy_i,
  input logic [7:0] bus_o,
  input logic       bus_oe_o,
  input logic       int_no,
  input logic       clk_ext_o,
  input logic [1:0] pd_mode_o,
  input logic       acq_ext_o,
  input logic       single_ended_o,
  input logic       unipolar_o,
  input logic [2:0] chan_o
);
  p_pd_keeps_clk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt_i && !wr_run_i) |=> $stable(clk_ext_o));

  p_deselect_cfg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable({pd_mode_o, acq_ext_o, single_ended_o, unipolar_o, chan_o, clk_ext_o}));

  p_deselect_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !bus_oe_o);

  p_hi_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && hben_i && unipolar_o) |-> (bus_o[7:2] == 6'b0));

  p_hi_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && hben_i && !unipolar_o) |-> (bus_o[7:2] == {6{bus_o[1]}}));

  p_int_from_conv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_no) |-> $past(busy_i));

  p_wr_sets_int_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt_i |=> int_no);
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cs_ni          (cs_ni),
  .hben_i         (hben_i),
  .wr_run_i       (bus_i[7]),
  .wr_evt_i       (wr_evt),
  .busy_i         (conv_busy),
  .bus_o          (bus_o),
  .bus_oe_o       (bus_oe_o),
  .int_no         (int_no),
  .clk_ext_o      (clk_ext_o),
  .pd_mode_o      (pd_mode_o),
  .acq_ext_o      (acq_ext_o),
  .single_ended_o (single_ended_o),
  .unipolar_o     (unipolar_o),
  .chan_o         (chan_o)
);

// File: tb/adc_bus_ctrl_tb_top.sv
module adc_bus_ctrl_tb_top;
  localparam int ACQ_T  = 6;
  localparam int EXT_T  = 10;
  localparam int INT_T  = 36;
  localparam int LAT    = ACQ_T + INT_T;
  localparam int EXT_N  = ACQ_T + EXT_T;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, wr_ni = 1'b1, rd_ni = 1'b1, hben_i = 1'b0, ext_clk_i = 1'b0;
  logic [7:0] bus_i = '0;
  logic [9:0] sample_i = '0;
  logic [7:0] bus_o;
  logic       bus_oe_o, int_no, clk_ext_o, acq_ext_o, single_ended_o, unipolar_o;
  logic [1:0] pd_mode_o;
  logic [2:0] chan_o;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  adc_bus_ctrl #(
    .RES_W(10), .ACQ_TICKS(ACQ_T), .EXT_CONV_TICKS(EXT_T), .INT_CONV_CYCLES(INT_T)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni), .rd_ni(rd_ni),
    .hben_i(hben_i), .ext_clk_i(ext_clk_i), .bus_i(bus_i), .sample_i(sample_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o), .int_no(int_no), .clk_ext_o(clk_ext_o),
    .pd_mode_o(pd_mode_o), .acq_ext_o(acq_ext_o), .single_ended_o(single_ended_o),
    .unipolar_o(unipolar_o), .chan_o(chan_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_bus(input logic [9:0] r, input bit hb, input bit uni);
    if (!hb) return r[7:0];
    return {{6{uni ? 1'b0 : r[9]}}, r[9:8]};
  endfunction

  function automatic logic [7:0] mk_byte(input bit ext, input bit acq, input bit sgl,
                                         input bit uni, input logic [2:0] ch);
    return {1'b1, ext, acq, sgl, uni, ch};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); cs_ni = 1'b0; wr_ni = 1'b0; bus_i = b;
    @(negedge clk); wr_ni = 1'b1;
  endtask

  task automatic rd_bus(input bit hb, output logic [7:0] v, output logic oe);
    @(negedge clk); cs_ni = 1'b0; rd_ni = 1'b0; hben_i = hb;
    @(negedge clk); v = bus_o; oe = bus_oe_o; rd_ni = 1'b1;
  endtask

  task automatic pulse(input int n);
    repeat (n) begin
      @(negedge clk); ext_clk_i = 1'b1;
      @(negedge clk); ext_clk_i = 1'b0;
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, b;
    logic       oe;
    logic [9:0] s;
    void'($urandom(32'h5a17));

    cyc(3);
    // R4 reset state
    chk("R4 clk_ext", clk_ext_o, 1);
    chk("R4 int", int_no, 1);
    chk("R4 oe", bus_oe_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    cyc(2);
    chk("R4 clk_ext after release", clk_ext_o, 1);

    // random mix over both clock sources and polarities
    for (int it = 0; it < 24; it++) begin
      bit ext = 1'($urandom % 2);
      bit uni = 1'($urandom % 2);
      bit sgl = 1'($urandom % 2);
      logic [2:0] ch = 3'($urandom % 8);
      s = 10'($urandom);
      if (it == 0) begin s = 10'h3ff; uni = 1'b0; end
      if (it == 1) begin s = 10'h200; uni = 1'b1; end
      if (it == 2) begin s = 10'h1ff; uni = 1'b0; end
      sample_i = s;
      b = mk_byte(ext, 1'b0, sgl, uni, ch);
      wr_byte(b);
      chk("R1 fields", {pd_mode_o, acq_ext_o, single_ended_o, unipolar_o, chan_o}, b);
      chk("R2 clock source", clk_ext_o, ext);
      if (ext) begin
        pulse(EXT_N - 1);
        chk("R9 int before last tick", int_no, 1);
        pulse(1);
        chk("R9 int at last tick", int_no, 0);
      end else begin
        cyc(LAT - 1);
        chk("R8 int one edge early", int_no, 1);
        cyc(1);
        chk("R8 int on time", int_no, 0);
      end
      rd_bus(1'b0, v, oe);
      chk("R6 low byte", v, exp_bus(s, 1'b0, uni));
      chk("R6 oe", oe, 1);
      chk("R10 read clears int", int_no, 1);
      rd_bus(1'b1, v, oe);
      chk("R7 high byte", v, exp_bus(s, 1'b1, uni));
      @(negedge clk); cs_ni = 1'b0;
      chk("R6 oe idle", bus_oe_o, 0);
    end

    // R3: power-down keeps internal source and cancels conversion
    wr_byte(8'b1000_0000);
    chk("R2 internal", clk_ext_o, 0);
    cyc(10);
    wr_byte(8'b0100_0101);
    chk("R3 source kept", clk_ext_o, 0);
    chk("R3 pd field", pd_mode_o, 2'b01);
    cyc(LAT + 5);
    chk("R3 no conversion", int_no, 1);
    // R3: power-down keeps external source
    wr_byte(8'b1100_0000);
    wr_byte(8'b0000_0000);
    chk("R3 ext kept", clk_ext_o, 1);

    // R10: write clears a pending done flag
    wr_byte(8'b1000_1000);
    cyc(LAT);
    chk("R10 done pending", int_no, 0);
    wr_byte(8'b0000_1000);
    chk("R10 write clears int", int_no, 1);

    // R11: restart mid-conversion
    wr_byte(8'b1000_0000);
    cyc(20);
    wr_byte(8'b1000_0000);
    cyc(LAT - 1);
    chk("R11 restarted timing early", int_no, 1);
    cyc(1);
    chk("R11 restarted timing", int_no, 0);
    rd_bus(1'b0, v, oe);

    // R12: open-ended acquisition then immediate conversion
    wr_byte(8'b1010_1000);
    chk("R12 acq field", acq_ext_o, 1);
    cyc(LAT + 20);
    chk("R12 hold no done", int_no, 1);
    wr_byte(8'b1000_1000);
    cyc(INT_T - 1);
    chk("R12 conv early", int_no, 1);
    cyc(1);
    chk("R12 conv done", int_no, 0);
    rd_bus(1'b0, v, oe);

    // R13: write on the completion edge
    sample_i = 10'h0a5;
    wr_byte(8'b1000_1000);
    cyc(LAT);
    rd_bus(1'b0, v, oe);
    chk("R13 setup result", v, 8'ha5);
    wr_byte(8'b1000_1000);
    sample_i = 10'h15a;
    cyc(LAT - 2);
    wr_byte(8'b1000_1000);
    chk("R13 write wins int", int_no, 1);
    rd_bus(1'b0, v, oe);
    chk("R13 result kept", v, 8'ha5);
    cyc(LAT - 2);
    chk("R13 new run done", int_no, 0);
    rd_bus(1'b0, v, oe);
    chk("R13 new result", v, 8'h5a);

    // R5: deselected bus ignores strobes and external clock
    wr_byte(8'b1100_1011);
    @(negedge clk); cs_ni = 1'b1; wr_ni = 1'b0; bus_i = 8'b1001_0100;
    @(negedge clk); wr_ni = 1'b1;
    chk("R5 fields kept", {pd_mode_o, acq_ext_o, single_ended_o, unipolar_o, chan_o}, 8'b1100_1011);
    rd_ni = 1'b0;
    @(negedge clk);
    chk("R5 bus hiz", bus_oe_o, 0);
    rd_ni = 1'b1;
    pulse(EXT_N + 4);
    chk("R5 ext clock ignored", int_no, 1);
    @(negedge clk); cs_ni = 1'b0;
    pulse(EXT_N - 1);
    chk("R5 count only selected", int_no, 1);
    pulse(1);
    chk("R9 done after selected ticks", int_no, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule